// File: doc/BRIEF.md
# Fractional Baud Clock Generator

This block derives the bit-rate timing of a serial port from a fixed reference clock. A rational stage comes first. It is a phase accumulator driven by a 24-bit step value and a 24-bit modulus, and it emits single-cycle sample enables whose average rate is the reference frequency times step/modulus. An integer prescaler follows and collapses a programmable number of those enables into one bit tick. When the prescaler holds 16, the sample enable serves directly as the 16x oversampling strobe of a conventional UART core. The bit tick marks the start of each bit period.

Software programs three 32-bit word registers through a simple write port. A read port with one cycle of latency returns the stored values. Any write to one of the three registers restarts both counting stages, so a new setting starts from a clean phase. Settings that would push the sample rate above the reference rate stop all output, and so does a zero modulus.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the prescaler reads 16, the step and the modulus read 0, and both outputs stay low. The register byte offsets are 0x30 (prescaler, low 8 bits), 0x34 (step, low 24 bits) and 0x38 (modulus, low 24 bits). Unused upper bits read 0, and `rd_data` shows the register selected by `rd_addr` one clock after it is presented.
- R2: With a valid setting (modulus nonzero, step ≤ modulus), the write edge of the last register counts as edge 0. The number of `sample_en` pulses seen after edges 1..L is exactly floor(L·step/modulus), and the m-th pulse follows edge ceil(m·modulus/step).
- R3: When step equals modulus, `sample_en` is high on every cycle from edge 1 on.
- R4: When the modulus is 0, or the step is greater than the modulus, neither `sample_en` nor `bit_tick` ever pulses.
- R5: `bit_tick` pulses for one cycle, one clock after every P-th `sample_en` pulse, where P is the prescaler value.
- R6: A prescaler value of 0 behaves as 1.
- R7: A write to any of the three registers clears the accumulator and the prescaler count, so the pulse schedule of R2 and R5 restarts from that write edge with no shortened first period.
- R8: A write to any other offset changes no register and does not disturb the running pulse schedule.
- R9: Over a window of N cycles, the count of `bit_tick` pulses is within ±1 of floor(N·step/(modulus·P)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset to read |
| rd_data | output | 32 | Registered read data |
| sample_en | output | 1 | Fractional-stage enable pulse (16x strobe when prescaler is 16) |
| bit_tick | output | 1 | One pulse per bit period |

## Verification
Some properties are checked on every cycle by the embedded assertions: the accumulator stays below the modulus, an invalid setting produces no enables, the full-rate case pulses continuously, the prescaler count stays inside its range, a bit tick is always preceded by an enable, a register write clears the pipeline, and an unmapped write leaves every register stable. The exact cycle of every bit tick after a reconfiguration, the exact enable count over a window, the treatment of a zero prescaler and the long-run average rate can only be shown by the bench. It does this with a scoreboard of predicted tick cycles computed from the rational formula.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam logic [7:0] OFS_PRESCALE = 8'h30;
  localparam logic [7:0] OFS_STEP     = 8'h34;
  localparam logic [7:0] OFS_MODULUS  = 8'h38;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PRESCALE,
    SEL_STEP,
    SEL_MODULUS
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [7:0] ofs);
    case (ofs)
      OFS_PRESCALE: decode_offset = SEL_PRESCALE;
      OFS_STEP:     decode_offset = SEL_STEP;
      OFS_MODULUS:  decode_offset = SEL_MODULUS;
      default:      decode_offset = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int FRAC_W   = 24,
  parameter int PS_W     = 8,
  parameter int PS_RESET = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [PS_W-1:0]   prescale,
  output logic [FRAC_W-1:0] step,
  output logic [FRAC_W-1:0] modulus,
  output logic              cfg_restart
);
  localparam int PS_PAD   = DATA_W - PS_W;
  localparam int FRAC_PAD = DATA_W - FRAC_W;

  reg_sel_e wr_sel;
  reg_sel_e rd_sel;

  assign wr_sel      = wr_en ? decode_offset(8'(wr_addr)) : SEL_NONE;
  assign rd_sel      = decode_offset(8'(rd_addr));
  assign cfg_restart = (wr_sel != SEL_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      prescale <= PS_W'(PS_RESET);
      step     <= '0;
      modulus  <= '0;
    end else begin
      case (wr_sel)
        SEL_PRESCALE: prescale <= wr_data[PS_W-1:0];
        SEL_STEP:     step     <= wr_data[FRAC_W-1:0];
        SEL_MODULUS:  modulus  <= wr_data[FRAC_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        SEL_PRESCALE: rd_data <= {{PS_PAD{1'b0}}, prescale};
        SEL_STEP:     rd_data <= {{FRAC_PAD{1'b0}}, step};
        SEL_MODULUS:  rd_data <= {{FRAC_PAD{1'b0}}, modulus};
        default:      rd_data <= '0;
      endcase
    end
  end

  // R8: a write outside the map leaves every register untouched
  assert_unmapped_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cfg_restart) |=> ($stable(prescale) && $stable(step) && $stable(modulus)));
endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc #(
  parameter int FRAC_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [FRAC_W-1:0] step,
  input  logic [FRAC_W-1:0] modulus,
  output logic              pulse
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  mod_ext;
  logic              cfg_ok;
  logic              wrap;

  assign cfg_ok  = (modulus != '0) && (step <= modulus);
  assign sum     = {1'b0, acc_q} + {1'b0, step};
  assign mod_ext = {1'b0, modulus};
  assign wrap    = (sum >= mod_ext);

  always_ff @(posedge clk) begin
    if (rst || restart || !cfg_ok) begin
      acc_q <= '0;
      pulse <= 1'b0;
    end else if (wrap) begin
      acc_q <= FRAC_W'(sum - mod_ext);
      pulse <= 1'b1;
    end else begin
      acc_q <= FRAC_W'(sum);
      pulse <= 1'b0;
    end
  end

  // R2: the phase stays strictly below the modulus while running
  assert_phase_bounded_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_ok && !restart) |=> (acc_q < $past(modulus)));
  // R4: an unusable setting yields no enable and a cleared phase
  assert_invalid_silent_R4: assert property (@(posedge clk) disable iff (rst)
    !cfg_ok |=> (!pulse && acc_q == '0));
  // R3: equal step and modulus gives an enable on every cycle
  assert_full_rate_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_ok && step == modulus && !restart) |=> pulse);
endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            pulse_in,
  input  logic [PS_W-1:0] prescale,
  output logic            tick
);
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] ps_eff;
  logic            last;

  assign ps_eff = (prescale == '0) ? PS_W'(1) : prescale;
  assign last   = (cnt_q == ps_eff - PS_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (pulse_in) begin
      cnt_q <= last ? '0 : cnt_q + PS_W'(1);
      tick  <= last;
    end else begin
      tick  <= 1'b0;
    end
  end

  // R5: a bit tick always follows an enable pulse
  assert_tick_after_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(pulse_in));
  // R6: the count never reaches the effective prescale (zero counts as one)
  assert_count_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q < ps_eff);
  // R7: a register write clears the count and holds off the tick
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!tick && cnt_q == '0));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int FRAC_W   = 24,
  parameter int PS_W     = 8,
  parameter int PS_RESET = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sample_en,
  output logic              bit_tick
);
  logic [PS_W-1:0]   prescale;
  logic [FRAC_W-1:0] step;
  logic [FRAC_W-1:0] modulus;
  logic              cfg_restart;

  fbg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W),
    .PS_W(PS_W), .PS_RESET(PS_RESET)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .prescale(prescale), .step(step), .modulus(modulus),
    .cfg_restart(cfg_restart)
  );

  fbg_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst(rst), .restart(cfg_restart),
    .step(step), .modulus(modulus), .pulse(sample_en)
  );

  fbg_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst(rst), .restart(cfg_restart),
    .pulse_in(sample_en), .prescale(prescale), .tick(bit_tick)
  );

  // R1: outputs are quiet in the first cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> (!sample_en && !bit_tick));
endmodule

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        sample_en;
  logic        bit_tick;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  longint exp_q[$];
  longint mon_idx = 0;
  bit     mon_en = 1'b0;
  longint s_count = 0;
  longint t_count = 0;

  always #5 clk = ~clk;

  frac_baud_gen i_frac_baud_gen (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .sample_en(sample_en), .bit_tick(bit_tick)
  );

  function automatic bit is_mapped(input logic [7:0] a);
    return (a == 8'h30) || (a == 8'h34) || (a == 8'h38);
  endfunction

  // edge index since the latest write to a mapped register
  always @(posedge clk) begin
    if (wr_en && is_mapped(wr_addr)) mon_idx <= 0;
    else mon_idx <= mon_idx + 1;
  end

  // monitor: pops predicted tick edges and compares
  always @(negedge clk) begin
    if (mon_en) begin
      if (sample_en) s_count++;
      if (bit_tick) begin
        t_count++;
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R5: tick at edge %0d, expected none", mon_idx);
        end else begin
          longint e;
          e = exp_q.pop_front();
          if (e != mon_idx) begin
            failures++;
            $display("FAIL R5/R7: tick at edge %0d, expected edge %0d", mon_idx, e);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic reg_read_check(input logic [7:0] a, input longint expv, input string req);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(rd_data == 32'(expv), req, rd_data, expv);
  endtask

  // program a setting and load the scoreboard with predicted tick edges
  task automatic start_cfg(input longint ps, input longint st, input longint md, input longint win);
    longint pe;
    mon_en = 1'b0;
    reg_write(8'h30, 32'(ps));
    reg_write(8'h34, 32'(st));
    reg_write(8'h38, 32'(md));
    exp_q.delete();
    s_count = 0;
    t_count = 0;
    pe = (ps == 0) ? 1 : ps;
    if (md != 0 && st != 0 && st <= md) begin
      for (longint j = 1; ; j++) begin
        longint m, k;
        m = j * pe;
        k = (m * md + st - 1) / st;
        if (k + 1 > win) break;
        exp_q.push_back(k + 1);
      end
    end
    mon_en = 1'b1;
  endtask

  task automatic finish_cfg(input longint ps, input longint st, input longint md,
                            input longint win, input string req);
    longint pe, exp_s, exp_t, diff;
    @(negedge clk);
    while (mon_idx < win) @(negedge clk);
    #1 mon_en = 1'b0;
    pe = (ps == 0) ? 1 : ps;
    check(exp_q.size() == 0, {req, " missing ticks"}, exp_q.size(), 0);
    exp_s = (md != 0 && st <= md) ? (win * st) / md : 0;
    check(s_count == exp_s, {req, " R2 enable count"}, s_count, exp_s);
    exp_t = (md != 0 && st <= md) ? (win * st) / (md * pe) : 0;
    diff = t_count - exp_t;
    check(diff >= -1 && diff <= 1, {req, " R9 tick count"}, t_count, exp_t);
  endtask

  task automatic run_cfg(input longint ps, input longint st, input longint md,
                         input longint win, input string req);
    start_cfg(ps, st, md, win);
    finish_cfg(ps, st, md, win, req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!sample_en && !bit_tick, "R1 outputs idle", {sample_en, bit_tick}, 0);
    reg_read_check(8'h30, 16, "R1 prescale reset");
    reg_read_check(8'h34, 0, "R1 step reset");
    reg_read_check(8'h38, 0, "R1 modulus reset");
    repeat (20) @(negedge clk);
    check(!sample_en && !bit_tick, "R1 disabled until programmed", {sample_en, bit_tick}, 0);

    // R2 R5 R9: classic 16x oversampling with a fractional ratio
    run_cfg(16, 3, 7, 2000, "R2");
    reg_read_check(8'h34, 3, "R1 step readback");
    reg_read_check(8'h38, 7, "R1 modulus readback");

    // R3: full rate
    run_cfg(1, 5, 5, 100, "R3");
    run_cfg(4, 1, 1, 100, "R3 prescaled");

    // R6: zero prescale acts as one
    run_cfg(0, 1, 3, 300, "R6");
    reg_read_check(8'h30, 0, "R6 prescale readback");

    // R4: zero modulus and step above modulus
    run_cfg(1, 9, 0, 200, "R4 zero modulus");
    run_cfg(1, 9, 4, 200, "R4 step above modulus");

    // R7: reconfigure mid-run, schedule restarts from the new write
    start_cfg(3, 5, 11, 500);
    repeat (37) @(negedge clk);
    run_cfg(3, 5, 11, 600, "R7 restart");
    start_cfg(2, 2, 9, 400);
    repeat (23) @(negedge clk);
    run_cfg(5, 7, 8, 600, "R7 new setting");

    // R8: unmapped write during a run
    start_cfg(2, 3, 10, 800);
    repeat (45) @(negedge clk);
    reg_write(8'h3C, 32'hFFFF_FFFF);
    reg_write(8'h00, 32'h0000_0001);
    reg_read_check(8'h30, 2, "R8 prescale kept");
    reg_read_check(8'h34, 3, "R8 step kept");
    reg_read_check(8'h38, 10, "R8 modulus kept");
    finish_cfg(2, 3, 10, 800, "R8 schedule kept");

    // R1 R9: widest field values and upper bits masked
    run_cfg(3, 24'hFFFFFE, 24'hFFFFFF, 3000, "R9 wide");
    reg_write(8'h34, 32'hAB12_3456);
    reg_read_check(8'h34, 32'h0012_3456, "R1 step upper bits");
    run_cfg(16, 24'hFFFFFF, 24'hFFFFFF, 400, "R9 max");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule